// File: doc/BRIEF.md
# Single-Cell Charge Phase Sequencer

This block steers one charge cycle of a single lithium-ion cell. It has no analog parts. Comparator flags tell it where the battery stands: below the low-voltage threshold, at the regulation voltage, below the recharge level, or with current under the done threshold. Other flags report input validity and die temperature. An enable and a two-bit mode code come from a one-wire mode decoder. From these the block produces four results: a phase, a code that selects the current limit for the analog loop, a pass-transistor enable, and a request to pull the charge-status line low.

The cycle runs idle, then precharge, then constant-current, then constant-voltage. The low-threshold flag is filtered with two different windows. It must clear for a short window before fast charge begins, and it must be present for a long window before the block falls back to precharge. Once the current drops below the done threshold, the status output is released and stays released until the device is disabled or loses input power, even while refresh charging goes on. A production-test mode bypasses the battery cycle and drives a fixed regulation code. Thermal shutdown still applies in that mode; thermal fold-back does not. No safety timer exists in this block; the host owns that job.

Top module: `charge_seq`

## Requirements
- R1: From idle, phase (encoding idle 0, precharge 1, constant-current 2, constant-voltage 3, test 4) moves to precharge only when `en`, `in_valid` and `bat_below_rch` are all high.
- R2: In precharge, `ilim_sel` (encoding off 0, 20% of resistor value 1, low USB 2, high USB 3, resistor value 4, test 5, thermal fold 6) is 1 in every mode. The one exception is mode 2 (low USB) with `pre_above_lo` high, which gives 2.
- R3: Precharge goes to constant-current only after `bat_low` has been low for `LOW_CLR_CYC` consecutive cycles. Constant-current or constant-voltage falls back to precharge only after `bat_low` has been high for `LOW_SET_CYC` consecutive cycles. Shorter excursions have no effect on phase.
- R4: In constant-current and constant-voltage, mode 0 (high USB) gives code 3, or code 4 when `rset_below_hi` is high. Mode 1 (resistor) gives 4. Mode 2 (low USB) gives 2.
- R5: Constant-current moves to constant-voltage while `bat_at_reg` is high. Constant-voltage returns to constant-current when it clears.
- R6: In constant-voltage with `ibat_below_done` high, `stat_pull_low` is released and `pass_en` stays high.
- R7: `stat_pull_low` is high in the three charge phases until done is latched. It then stays low through later constant-current, constant-voltage and precharge passes.
- R8: `temp_shut` turns `pass_en` off, sets the code to 0 and releases the status. They recover only after `temp_cool` is seen, not merely when `temp_shut` drops.
- R9: `temp_reg` forces code 6 in the charge phases and is ignored in test.
- R10: Mode 3 with `en` and `in_valid` enters test regardless of the battery flags. Test gives code 5, `pass_en` high and status released, and thermal shutdown still applies.
- R11: Low `en` or low `in_valid` returns the block to idle with `pass_en` low and code 0, and clears the latched done state. Reset gives the same outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Device enable from mode decoder |
| in_valid | input | 1 | Input supply within valid window |
| mode_code | input | 2 | 0 high USB, 1 resistor, 2 low USB, 3 test |
| bat_low | input | 1 | Battery below low-voltage threshold |
| bat_at_reg | input | 1 | Battery at regulation voltage |
| bat_below_rch | input | 1 | Battery below recharge level |
| ibat_below_done | input | 1 | Charge current below done threshold |
| rset_below_hi | input | 1 | Resistor-set current below high USB limit |
| pre_above_lo | input | 1 | 20% resistor current above low USB limit |
| temp_reg | input | 1 | Die above regulation temperature |
| temp_shut | input | 1 | Die above shutdown temperature |
| temp_cool | input | 1 | Die below shutdown minus hysteresis |
| phase | output | 3 | Current charge phase |
| ilim_sel | output | 3 | Current-limit select code |
| pass_en | output | 1 | Pass-transistor enable |
| stat_pull_low | output | 1 | Request to pull status line low |

## Verification
The phase register samples its inputs at one edge and shows the new phase after that edge. `ilim_sel`, `pass_en` and `stat_pull_low` are registered from the phase, done and thermal state, so they follow one edge later. A change in `temp_shut` or `ibat_below_done` reaches the outputs two edges after it is sampled. The filtered low-threshold transitions take the filter window plus one edge. The bench drives inputs on the falling edge and, for plain transitions, samples three falling edges later. For the filtered transitions it checks from both sides: the old phase at window minus two, the new phase at window plus three. This keeps every sample clear of the edge at which the result changes.

// File: rtl/charge_seq_pkg.sv
// Shared encodings for the charge phase sequencer.
// Assumes: phase, mode and limit codes are decoded by neighbours by value.
package charge_seq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_PRE  = 3'd1,
        PH_CC   = 3'd2,
        PH_CV   = 3'd3,
        PH_TEST = 3'd4
    } phase_t;

    typedef enum logic [1:0] {
        MD_USB_HI = 2'd0,
        MD_RSET   = 2'd1,
        MD_USB_LO = 2'd2,
        MD_TEST   = 2'd3
    } mode_t;

    typedef enum logic [2:0] {
        LIM_OFF    = 3'd0,
        LIM_PRE    = 3'd1,
        LIM_USB_LO = 3'd2,
        LIM_USB_HI = 3'd3,
        LIM_RSET   = 3'd4,
        LIM_TEST   = 3'd5,
        LIM_FOLD   = 3'd6
    } lim_t;

    // True for the three battery charge phases.
    function automatic logic is_charging(input phase_t p);
        return (p == PH_PRE) || (p == PH_CC) || (p == PH_CV);
    endfunction

endpackage

// File: rtl/cs_deglitch.sv
// Asymmetric level filter. The output takes a new level only after the raw
// input has differed from it for a run of consecutive cycles: SET_CYC to go
// 0->1, CLR_CYC to go 1->0. A synchronous clear forces the INIT level.
// Assumes: raw is already synchronous to clk.
module cs_deglitch #(
    parameter int  SET_CYC = 100,
    parameter int  CLR_CYC = 10,
    parameter logic INIT   = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic raw,
    output logic filt
);
    localparam int MAXC = (SET_CYC > CLR_CYC) ? SET_CYC : CLR_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] need;

    // Window length for the transition currently pending.
    always_comb need = filt ? CW'(CLR_CYC) : CW'(SET_CYC);

    // Count consecutive disagreeing cycles and flip at the window end.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            filt <= INIT;
            cnt  <= '0;
        end else if (raw == filt) begin
            cnt <= '0;
        end else if (cnt == need - CW'(1)) begin
            filt <= raw;
            cnt  <= '0;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end

endmodule

// File: rtl/cs_thermal.sv
// Thermal shutdown latch with hysteresis: sets on the shutdown flag, clears
// only once the cool flag is seen with the shutdown flag absent.
// Assumes: temperature comparators are synchronous to clk.
module cs_thermal (
    input  logic clk,
    input  logic rst_n,
    input  logic temp_shut,
    input  logic temp_cool,
    output logic hot
);
    // Hold the shutdown state across the hysteresis band.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hot <= 1'b0;
        else if (temp_shut)
            hot <= 1'b1;
        else if (temp_cool)
            hot <= 1'b0;
    end

endmodule

// File: rtl/cs_phase_fsm.sv
// Phase state machine and latched charge-done flag. Uses the filtered
// low-battery level for precharge/fast-charge moves and raw flags for the
// rest. Drives a clear to the filter while not charging.
// Assumes: low_f comes from cs_deglitch initialised to "low".
module cs_phase_fsm
    import charge_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   en,
    input  logic   in_valid,
    input  mode_t  mode,
    input  logic   bat_below_rch,
    input  logic   low_f,
    input  logic   bat_at_reg,
    input  logic   ibat_below_done,
    output phase_t phase,
    output logic   done,
    output logic   dg_clr
);
    phase_t nxt;

    // Filter restarts from "low" whenever no battery cycle is running.
    always_comb dg_clr = (phase == PH_IDLE) || (phase == PH_TEST);

    // Next-phase decision.
    always_comb begin
        nxt = phase;
        if (!en || !in_valid) begin
            nxt = PH_IDLE;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (mode == MD_TEST)   nxt = PH_TEST;
                    else if (bat_below_rch) nxt = PH_PRE;
                end
                PH_PRE: begin
                    if (mode == MD_TEST)   nxt = PH_TEST;
                    else if (!low_f)       nxt = PH_CC;
                end
                PH_CC: begin
                    if (mode == MD_TEST)   nxt = PH_TEST;
                    else if (low_f)        nxt = PH_PRE;
                    else if (bat_at_reg)   nxt = PH_CV;
                end
                PH_CV: begin
                    if (mode == MD_TEST)   nxt = PH_TEST;
                    else if (low_f)        nxt = PH_PRE;
                    else if (!bat_at_reg)  nxt = PH_CC;
                end
                PH_TEST: begin
                    if (mode != MD_TEST)   nxt = PH_IDLE;
                end
                default: nxt = PH_IDLE;
            endcase
        end
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_IDLE;
        else        phase <= nxt;
    end

    // Done latch: set in constant-voltage at low current, cleared on exit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            done <= 1'b0;
        else if (nxt == PH_IDLE || nxt == PH_TEST)
            done <= 1'b0;
        else if (phase == PH_CV && ibat_below_done)
            done <= 1'b1;
    end

endmodule

// File: rtl/cs_limit_sel.sv
// Registered output stage: current-limit code, pass enable and status
// request, from phase, mode, thermal state and limit comparison flags.
// Assumes: comparison flags are static or synchronous to clk.
module cs_limit_sel
    import charge_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  phase_t     phase,
    input  mode_t      mode,
    input  logic       done,
    input  logic       hot,
    input  logic       temp_reg,
    input  logic       rset_below_hi,
    input  logic       pre_above_lo,
    output logic [2:0] ilim_sel,
    output logic       pass_en,
    output logic       stat_pull_low
);
    lim_t lim_c;
    lim_t fast_c;

    // Fast-charge code from the programmed mode, taking the lower limit.
    always_comb begin
        case (mode)
            MD_RSET:   fast_c = LIM_RSET;
            MD_USB_LO: fast_c = LIM_USB_LO;
            default:   fast_c = rset_below_hi ? LIM_RSET : LIM_USB_HI;
        endcase
    end

    // Code per phase with thermal fold and shutdown overrides.
    always_comb begin
        lim_c = LIM_OFF;
        if (hot) begin
            lim_c = LIM_OFF;
        end else if (phase == PH_TEST) begin
            lim_c = LIM_TEST;
        end else if (is_charging(phase) && temp_reg) begin
            lim_c = LIM_FOLD;
        end else if (phase == PH_PRE) begin
            lim_c = (mode == MD_USB_LO && pre_above_lo) ? LIM_USB_LO : LIM_PRE;
        end else if (phase == PH_CC || phase == PH_CV) begin
            lim_c = fast_c;
        end
    end

    // Output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ilim_sel      <= LIM_OFF;
            pass_en       <= 1'b0;
            stat_pull_low <= 1'b0;
        end else begin
            ilim_sel      <= lim_c;
            pass_en       <= (phase != PH_IDLE) && !hot;
            stat_pull_low <= is_charging(phase) && !done && !hot;
        end
    end

endmodule

// File: rtl/charge_seq.sv
// Charge phase sequencer top. Filters the low-battery flag, runs the phase
// machine, tracks thermal shutdown and registers the selection outputs.
// Assumes: all inputs synchronous to clk; window lengths in clock cycles.
module charge_seq #(
    parameter int LOW_CLR_CYC = 6250,
    parameter int LOW_SET_CYC = 3125000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       in_valid,
    input  logic [1:0] mode_code,
    input  logic       bat_low,
    input  logic       bat_at_reg,
    input  logic       bat_below_rch,
    input  logic       ibat_below_done,
    input  logic       rset_below_hi,
    input  logic       pre_above_lo,
    input  logic       temp_reg,
    input  logic       temp_shut,
    input  logic       temp_cool,
    output logic [2:0] phase,
    output logic [2:0] ilim_sel,
    output logic       pass_en,
    output logic       stat_pull_low
);
    import charge_seq_pkg::*;

    mode_t  mode;
    phase_t ph;
    logic   low_f;
    logic   done;
    logic   dg_clr;
    logic   hot;

    always_comb mode  = mode_t'(mode_code);
    always_comb phase = ph;

    cs_deglitch #(
        .SET_CYC (LOW_SET_CYC),
        .CLR_CYC (LOW_CLR_CYC),
        .INIT    (1'b1)
    ) u_lowdg (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (dg_clr),
        .raw   (bat_low),
        .filt  (low_f)
    );

    cs_thermal u_therm (
        .clk       (clk),
        .rst_n     (rst_n),
        .temp_shut (temp_shut),
        .temp_cool (temp_cool),
        .hot       (hot)
    );

    cs_phase_fsm u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .en              (en),
        .in_valid        (in_valid),
        .mode            (mode),
        .bat_below_rch   (bat_below_rch),
        .low_f           (low_f),
        .bat_at_reg      (bat_at_reg),
        .ibat_below_done (ibat_below_done),
        .phase           (ph),
        .done            (done),
        .dg_clr          (dg_clr)
    );

    cs_limit_sel u_lim (
        .clk           (clk),
        .rst_n         (rst_n),
        .phase         (ph),
        .mode          (mode),
        .done          (done),
        .hot           (hot),
        .temp_reg      (temp_reg),
        .rset_below_hi (rset_below_hi),
        .pre_above_lo  (pre_above_lo),
        .ilim_sel      (ilim_sel),
        .pass_en       (pass_en),
        .stat_pull_low (stat_pull_low)
    );

endmodule

// File: rtl/charge_seq_chk.sv
// Port-level properties of the charge sequencer, bound to every instance.
module charge_seq_chk
    import charge_seq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       en,
    input logic       in_valid,
    input logic       bat_below_rch,
    input logic       temp_shut,
    input logic [2:0] phase,
    input logic [2:0] ilim_sel,
    input logic       pass_en,
    input logic       stat_pull_low
);
    assert_start_cond_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(phase) == PH_IDLE && phase == PH_PRE) |-> $past(en && in_valid && bat_below_rch));

    assert_idle_on_loss_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!en || !in_valid) |=> phase == PH_IDLE);

    assert_pass_needs_phase_R11: assert property (@(posedge clk) disable iff (!rst_n)
        pass_en |-> $past(phase) != PH_IDLE);

    assert_shutdown_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(temp_shut, 2) |-> !pass_en);

    assert_status_in_charge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stat_pull_low |-> ($past(phase) == PH_PRE || $past(phase) == PH_CC || $past(phase) == PH_CV));

    assert_test_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(phase) == PH_TEST && pass_en) |-> ilim_sel == LIM_TEST);
endmodule

bind charge_seq charge_seq_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .en            (en),
    .in_valid      (in_valid),
    .bat_below_rch (bat_below_rch),
    .temp_shut     (temp_shut),
    .phase         (phase),
    .ilim_sel      (ilim_sel),
    .pass_en       (pass_en),
    .stat_pull_low (stat_pull_low)
);

// File: tb/sim_charge_seq.sv
// Bench for charge_seq: directed sequence through a full cycle plus random
// mode and flag patterns in fast charge, checked against bench functions.
module sim_charge_seq;
    localparam int UPC = 8;
    localparam int DNC = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 0, in_valid = 0, bat_low = 0, bat_at_reg = 0;
    logic       bat_below_rch = 0, ibat_below_done = 0;
    logic       rset_below_hi = 0, pre_above_lo = 0;
    logic       temp_reg = 0, temp_shut = 0, temp_cool = 0;
    logic [1:0] mode_code = 2'd0;
    logic [2:0] phase, ilim_sel;
    logic       pass_en, stat_pull_low;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    charge_seq #(.LOW_CLR_CYC(UPC), .LOW_SET_CYC(DNC)) u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .in_valid(in_valid),
        .mode_code(mode_code), .bat_low(bat_low), .bat_at_reg(bat_at_reg),
        .bat_below_rch(bat_below_rch), .ibat_below_done(ibat_below_done),
        .rset_below_hi(rset_below_hi), .pre_above_lo(pre_above_lo),
        .temp_reg(temp_reg), .temp_shut(temp_shut), .temp_cool(temp_cool),
        .phase(phase), .ilim_sel(ilim_sel), .pass_en(pass_en),
        .stat_pull_low(stat_pull_low)
    );

    // Expected fast-charge code from R4.
    function automatic int exp_fast(input int md, input bit below_hi);
        if (md == 1) return 4;
        if (md == 2) return 2;
        return below_hi ? 4 : 3;
    endfunction

    // Expected code in a charge phase from R2, R4 and R9 (no shutdown).
    function automatic int exp_lim(input int ph, input int md, input bit below_hi,
                                   input bit above_lo, input bit treg);
        if (treg) return 6;
        if (ph == 1) return (md == 2 && above_lo) ? 2 : 1;
        return exp_fast(md, below_hi);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);
        chk("R11 reset phase", phase, 0);
        chk("R11 reset code", ilim_sel, 0);
        chk("R11 reset pass", pass_en, 0);
        chk("R7 reset status", stat_pull_low, 0);

        // R1: no start without recharge flag
        en = 1; in_valid = 1; bat_low = 1;
        wait_n(5);
        chk("R1 no start", phase, 0);
        bat_below_rch = 1;
        wait_n(3);
        chk("R1 start precharge", phase, 1);
        chk("R7 status in precharge", stat_pull_low, 1);
        chk("R2 precharge code mode0", ilim_sel, 1);
        mode_code = 2; pre_above_lo = 1;
        wait_n(3);
        chk("R2 precharge low-USB clamp", ilim_sel, 2);
        pre_above_lo = 0;
        wait_n(3);
        chk("R2 precharge low-USB no clamp", ilim_sel, 1);
        mode_code = 0;

        // R3: short clear is ignored
        bat_low = 0;
        wait_n(UPC - 3);
        bat_low = 1;
        wait_n(4);
        chk("R3 short clear ignored", phase, 1);
        bat_low = 0;
        wait_n(UPC - 2);
        chk("R3 before clear window", phase, 1);
        wait_n(5);
        chk("R3 after clear window", phase, 2);

        // R4: directed fast-charge codes
        rset_below_hi = 0; wait_n(3);
        chk("R4 high USB", ilim_sel, 3);
        rset_below_hi = 1; wait_n(3);
        chk("R4 high USB lower resistor", ilim_sel, 4);
        mode_code = 1; wait_n(3);
        chk("R4 resistor mode", ilim_sel, 4);
        mode_code = 2; wait_n(3);
        chk("R4 low USB", ilim_sel, 2);

        // R4 and R9: random patterns in constant-current
        for (int i = 0; i < 40; i++) begin
            int  md;
            bit  bh, al, tr;
            md = int'($urandom % 3);
            bh = 1'($urandom);
            al = 1'($urandom);
            tr = 1'($urandom);
            mode_code = 2'(md); rset_below_hi = bh; pre_above_lo = al; temp_reg = tr;
            wait_n(3);
            chk("R4/R9 random fast code", ilim_sel, exp_lim(2, md, bh, al, tr));
            chk("R5 stays constant-current", phase, 2);
        end
        mode_code = 0; rset_below_hi = 0; pre_above_lo = 0; temp_reg = 0;

        // R5: constant-voltage
        bat_at_reg = 1; wait_n(3);
        chk("R5 enter constant-voltage", phase, 3);
        bat_low = 1; wait_n(DNC / 2); bat_low = 0; wait_n(3);
        chk("R3 short low ignored", phase, 3);

        // R6 and R7: done latch
        ibat_below_done = 1; wait_n(3);
        chk("R6 status released", stat_pull_low, 0);
        chk("R6 pass stays on", pass_en, 1);
        ibat_below_done = 0; bat_at_reg = 0; wait_n(3);
        chk("R5 back to constant-current", phase, 2);
        chk("R7 released in refresh", stat_pull_low, 0);
        bat_at_reg = 1; wait_n(3);
        chk("R7 released back in CV", stat_pull_low, 0);

        // R3: long low falls back
        bat_low = 1;
        wait_n(DNC - 2);
        chk("R3 before set window", phase, 3);
        wait_n(5);
        chk("R3 after set window", phase, 1);
        chk("R7 released in precharge", stat_pull_low, 0);
        chk("R2 code after fallback", ilim_sel, 1);

        // R8: shutdown with hysteresis
        temp_shut = 1; wait_n(3);
        chk("R8 pass off", pass_en, 0);
        chk("R8 code off", ilim_sel, 0);
        temp_shut = 0; wait_n(3);
        chk("R8 hysteresis holds", pass_en, 0);
        temp_cool = 1; wait_n(3);
        chk("R8 recovered", pass_en, 1);
        temp_cool = 0;

        // R11: disable clears done
        en = 0; wait_n(3);
        chk("R11 idle on disable", phase, 0);
        chk("R11 pass off", pass_en, 0);
        chk("R11 code off", ilim_sel, 0);
        en = 1; wait_n(3);
        chk("R11 restart precharge", phase, 1);
        chk("R11 done cleared", stat_pull_low, 1);
        temp_shut = 1; wait_n(3);
        chk("R8 status released on fault", stat_pull_low, 0);
        temp_shut = 0; temp_cool = 1; wait_n(3);
        chk("R8 status back", stat_pull_low, 1);
        temp_cool = 0;
        in_valid = 0; wait_n(3);
        chk("R11 idle on invalid", phase, 0);
        chk("R11 status off", stat_pull_low, 0);

        // R10: test mode
        bat_below_rch = 0; mode_code = 3; in_valid = 1; wait_n(3);
        chk("R10 test phase", phase, 4);
        chk("R10 test code", ilim_sel, 5);
        chk("R10 pass on", pass_en, 1);
        chk("R10 status released", stat_pull_low, 0);
        temp_reg = 1; wait_n(3);
        chk("R9 fold ignored in test", ilim_sel, 5);
        temp_shut = 1; wait_n(3);
        chk("R10 shutdown applies", pass_en, 0);
        temp_shut = 0; temp_cool = 1; temp_reg = 0; wait_n(3);
        temp_cool = 0;
        mode_code = 0; wait_n(3);
        chk("R10 exit to idle", phase, 0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule